// File: doc/BRIEF.md
# Cascadable Latched Serial Status Readout

This block holds a snapshot of a row of filtered sensor states and sends it to a host's synchronous serial port one bit at a time. The host pulls an active-low strobe low, and that falling edge copies all sensor bits into an internal shift register in one step. Each rising edge of a separate shift clock from the host then moves the register one place toward the serial output. The output is inverted and open-drain. It is modelled as a drive-low enable: a stored 1 pulls the line low, and a stored 0 releases it.

Several of these blocks can be chained into one long register. Each serial output feeds the active-low extension input of the next block in the chain, and a single host reads the whole chain. An extension input left unconnected rests high because it is pulled up, so it shifts in logical 0s. The strobe, the shift clock and the extension input are all asynchronous to the system clock. Each one is synchronised, and its edges are detected in the system clock domain.

Top module: `serial_status_readout`

## Requirements
- R1: While reset is asserted, and directly after it ends, the shift register holds all zeros and the serial output is released (soDriveLow = 0).
- R2: A high-to-low transition of latchN copies sensorBits into the register. A low-to-high transition of latchN, or a change of sensorBits while no falling edge occurs, leaves the output unchanged.
- R3: Bit order: right after a load, the output shows channel 0 (sensorBits[0]). The k-th following shift shows channel k, so channel 7 is shown after seven shifts.
- R4: The register moves one place only on a low-to-high transition of serClk. A high-to-low transition of serClk, or a steady level, has no effect.
- R5: Output encoding: a stored logical 1 gives soDriveLow = 1 (line driven low), and a stored 0 gives soDriveLow = 0 (line released).
- R6: Cascade: each shift takes the inverted extN into the top position (extN = 0 enters as logical 1). After eight shifts, the output presents those extension bits in the order they entered.
- R7: With extN held high, as a pulled-up unconnected input, logical 0s enter. Eight shifts after any load, the output is released.
- R8: A falling latchN edge driven between clock edges changes the output on the third rising system clock edge after it, and not on the first or second.
- R9: While no latch falling edge and no shift rising edge occurs, soDriveLow keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (undervoltage or external reset) |
| sensorBits | input | WIDTH | Filtered sensor states; bit 0 is channel 0 |
| latchN | input | 1 | Active-low latch strobe; its falling edge loads sensorBits |
| serClk | input | 1 | Host shift clock; its rising edge shifts |
| extN | input | 1 | Active-low cascade input from the previous block's output |
| soDriveLow | output | 1 | Open-drain output enable: 1 pulls the line low |

## Verification
Each input passes through two synchroniser stages and one edge register before the shift register updates. A load or a shift therefore reaches soDriveLow on the third rising clock edge after the input moves. The R8 check samples on the falling edges after the second and third rising edges to pin down that exact cycle. Every other stimulus is held for four clock cycles before the output is compared with the bench's reference register, so those checks always fall after the result is due. The no-effect checks take a second sample four cycles after a falling serClk edge or a rising latchN edge, and before the next stimulus.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef struct packed {
    logic load;
    logic shift;
  } ctrlStrobeT;

  localparam int unsigned SIG_LATCH = 0;
  localparam int unsigned SIG_CLK   = 1;
  localparam int unsigned SIG_EXT   = 2;
  localparam int unsigned NUM_SIGS  = 3;

endpackage

// File: rtl/ssr_edge_ctrl.sv
module ssr_edge_ctrl
  import ssr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchN,
  input  logic       serClk,
  input  logic       extN,
  output ctrlStrobeT strobes,
  output logic       serIn
);

  // Reset levels chosen so no false edge appears at reset release:
  // latch rests low (no fall), clock rests high (no rise), ext rests high.
  localparam logic [NUM_SIGS-1:0] RST_VALS = 3'b110;
  localparam int unsigned CHAIN_LEN = SYNC_STAGES + 1;

  logic [NUM_SIGS-1:0] rawIn;
  logic [NUM_SIGS-1:0] curLvl;
  logic [NUM_SIGS-1:0] prevLvl;

  assign rawIn[SIG_LATCH] = latchN;
  assign rawIn[SIG_CLK]   = serClk;
  assign rawIn[SIG_EXT]   = extN;

  for (genvar g = 0; g < NUM_SIGS; g++) begin : gSync
    logic [CHAIN_LEN-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {CHAIN_LEN{RST_VALS[g]}};
      else       chain <= {chain[CHAIN_LEN-2:0], rawIn[g]};
    end
    assign curLvl[g]  = chain[SYNC_STAGES-1];
    assign prevLvl[g] = chain[SYNC_STAGES];
  end

  always_comb begin
    strobes.load  = prevLvl[SIG_LATCH] & ~curLvl[SIG_LATCH];
    strobes.shift = ~prevLvl[SIG_CLK] & curLvl[SIG_CLK];
  end

  assign serIn = ~curLvl[SIG_EXT];

  // R2: one latch edge yields a single-cycle load strobe
  p_load_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !strobes.load);

  // R4: one clock edge yields a single-cycle shift strobe
  p_shift_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> !strobes.shift);

endmodule

// File: rtl/ssr_shift_path.sv
module ssr_shift_path
  import ssr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic             serOut
);

  logic [WIDTH-1:0] dataReg;

  // Load wins over shift when both strobes meet in one cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataReg <= '0;
    else if (strobes.load)  dataReg <= parIn;
    else if (strobes.shift) dataReg <= {serIn, dataReg[WIDTH-1:1]};
  end

  assign serOut = dataReg[0];

  // R2: a load strobe captures the parallel bits
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> dataReg == $past(parIn));

  // R3: a shift moves every bit one place toward the output
  p_shift_move_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !strobes.load) |=> dataReg[WIDTH-2:0] == $past(dataReg[WIDTH-1:1]));

  // R6: the cascade bit enters at the top
  p_cascade_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !strobes.load) |=> dataReg[WIDTH-1] == $past(serIn));

endmodule

// File: rtl/serial_status_readout.sv
module serial_status_readout
  import ssr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sensorBits,
  input  logic             latchN,
  input  logic             serClk,
  input  logic             extN,
  output logic             soDriveLow
);

  ctrlStrobeT strobes;
  logic       serIn;

  ssr_edge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .latchN  (latchN),
    .serClk  (serClk),
    .extN    (extN),
    .strobes (strobes),
    .serIn   (serIn)
  );

  ssr_shift_path #(.WIDTH(WIDTH)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .parIn   (sensorBits),
    .serIn   (serIn),
    .serOut  (soDriveLow)
  );

  // R9: without any strobe the output stays put
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.shift) |=> $stable(soDriveLow));

endmodule

// File: tb/serial_status_readout_test.sv
module serial_status_readout_test;

  localparam int unsigned WIDTH = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic [WIDTH-1:0] sensorBits;
  logic             latchN;
  logic             serClk;
  logic             extN;
  logic             soDriveLow;

  int unsigned      checkCount = 0;
  int unsigned      failCount  = 0;
  logic [WIDTH-1:0] model;
  logic [WIDTH-1:0] extSeq;

  always #5 clk = ~clk;

  serial_status_readout #(.WIDTH(WIDTH)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .sensorBits (sensorBits),
    .latchN     (latchN),
    .serClk     (serClk),
    .extN       (extN),
    .soDriveLow (soDriveLow)
  );

  function automatic logic [WIDTH-1:0] shiftModel(logic [WIDTH-1:0] cur, logic ext);
    return {~ext, cur[WIDTH-1:1]};
  endfunction

  task automatic check(string req, logic act, logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: soDriveLow=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLatch(logic [WIDTH-1:0] bits);
    sensorBits = bits;
    latchN = 1'b0;
    waitCycles(4);
    model = bits;
    check("R2/R3/R5 load", soDriveLow, model[0]);
    sensorBits = ~bits;          // R2: changes after the edge are ignored
    latchN = 1'b1;               // R2: rising edge does not load
    waitCycles(4);
    check("R2 no reload", soDriveLow, model[0]);
  endtask

  task automatic doShift(logic ext);
    extN = ext;
    waitCycles(4);
    serClk = 1'b1;
    waitCycles(4);
    model = shiftModel(model, ext);
    check("R3/R4/R6 shift", soDriveLow, model[0]);
    serClk = 1'b0;               // R4: falling edge does nothing
    waitCycles(4);
    check("R4 falling edge ignored", soDriveLow, model[0]);
  endtask

  initial begin : watchdog
    #1_000_000;
    failCount++;
    checkCount++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin : stim
    rstN = 1'b0; latchN = 1'b1; serClk = 1'b0; extN = 1'b1; sensorBits = '0;
    model = '0;
    void'($urandom(32'h5EED_1234));
    waitCycles(5);
    check("R1 reset released", soDriveLow, 1'b0);
    rstN = 1'b1;
    waitCycles(5);
    check("R1 after reset", soDriveLow, 1'b0);

    // R8: latency of a falling latch edge, three rising clock edges
    sensorBits = 8'h01;
    latchN = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 not after two edges", soDriveLow, 1'b0);
    @(negedge clk);
    check("R8 after third edge", soDriveLow, 1'b1);
    model = 8'h01;
    latchN = 1'b1;
    waitCycles(4);

    // R9: idle hold while sensor bits move
    sensorBits = 8'h00;
    waitCycles(10);
    check("R9 idle hold", soDriveLow, 1'b1);

    // R3: walking order with directed pattern, channel 7 after seven shifts
    doLatch(8'h80);
    for (int i = 0; i < 7; i++) doShift(1'b1);
    check("R3 channel 7 last", soDriveLow, 1'b1);
    // R7: pulled-up extension drains to released
    doShift(1'b1);
    check("R7 drained", soDriveLow, 1'b0);

    // R6: cascade bits reappear in order after a full register length
    doLatch(8'hA5);
    extSeq = 8'b0110_1100;
    for (int i = 0; i < WIDTH; i++) doShift(extSeq[i]);
    for (int i = 0; i < WIDTH; i++) begin
      check("R6 cascade order", soDriveLow, ~extSeq[i]);
      doShift(1'b1);
    end

    // Random loads and shifts against the bench model
    for (int it = 0; it < 30; it++) begin
      doLatch(WIDTH'($urandom));
      for (int s = 0; s < 10; s++) doShift(1'($urandom));
    end

    // R1: reset mid-stream clears and releases
    doLatch(8'hFF);
    rstN = 1'b0;
    waitCycles(3);
    check("R1 reset mid-run", soDriveLow, 1'b0);
    rstN = 1'b1;
    model = '0;
    waitCycles(5);
    check("R1 cleared after release", soDriveLow, 1'b0);
    for (int i = 0; i < WIDTH; i++) doShift(1'b1);
    check("R7 zeros after reset", soDriveLow, 1'b0);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule